// File: doc/BRIEF.md
# Set-Associative Branch Target Predictor

This block sits in the fetch stage of a small pipeline. It keeps a record of recent taken branches, each with a target address and a two-bit direction counter. The fetch unit sends a branch address on a valid/ready lookup channel. One cycle later the block answers with a hit flag, a taken or not-taken guess and a predicted target. The answer is held in a single response register. A lookup is accepted only when that register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response does not change and no new lookup is accepted.

When a branch resolves, the back end presents its address, its actual direction and its actual target on the update pins. Updates cannot be back-pressured: one is taken on every cycle in which `upd_valid` is high. The block compares the resolved outcome with what its table would have predicted for that branch. In the following cycle it raises a one-cycle `mispredict` pulse that a pipeline can use to redirect fetch.

A branch that misses and then resolves taken is written into its set. If the set is full, the least recently used way is evicted to make room. A synchronous `flush` input forgets every entry.

Top module: `btb_predictor`

## Requirements
- R1: After reset, `rsp_valid` and `mispredict` are 0, `lkp_ready` is 1, and every lookup misses until an entry is allocated.
- R2: The set is `addr[SET_W-1:0]` and the tag is the remaining upper bits. An address that differs from a stored branch only in its tag bits misses.
- R3: A lookup miss returns `rsp_hit`=0, `rsp_taken`=0 and `rsp_target`=0.
- R4: A lookup hit returns `rsp_hit`=1 and the stored target. `rsp_taken` is 1 exactly when the entry's counter is 2 or 3.
- R5: An update that misses with taken=1 allocates the branch with counter value 2 and the resolved target, and it causes a mispredict pulse.
- R6: An update that misses with taken=0 allocates nothing and causes no mispredict.
- R7: An update that hits moves the counter one step up (taken) or down (not taken), saturating at 3 and 0. A taken update also replaces the stored target with the resolved one.
- R8: `mispredict` is high for one cycle, the cycle after an update, in either of two cases. The first is that the predicted direction differs from the resolved one. The second is that both are taken and the stored target differs from the resolved target.
- R9: An allocation uses the lowest-numbered invalid way of the set. If the set has no invalid way, it uses the least recently used way. Only update hits and allocations count as uses; lookups do not.
- R10: Once a set holds as many distinct branches as it has ways, allocating one more distinct branch there displaces one of them. A later lookup of the displaced branch misses.
- R11: `flush` invalidates every entry in one cycle. It takes priority over an update in the same cycle, which then changes nothing and causes no mispredict.
- R12: `lkp_ready` equals `!rsp_valid || rsp_ready`. An accepted lookup is answered in the next cycle, using the table state from before any update in the same cycle. A stalled response holds all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup request can be accepted |
| lkp_addr | input | ADDR_W | Branch address to look up |
| rsp_valid | output | 1 | Prediction response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Branch found in the table |
| rsp_taken | output | 1 | Predicted direction |
| rsp_target | output | ADDR_W | Predicted target, 0 on miss |
| upd_valid | input | 1 | Resolved branch present |
| upd_addr | input | ADDR_W | Resolved branch address |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target |
| mispredict | output | 1 | One-cycle pulse after a mispredicted update |

## Verification
The bench builds the block with its defaults: 16 sets, 4 ways and 32-bit addresses. Directed sequences confine traffic to one or two sets, so five distinct branches push a full set into least-recently-used eviction. Counter saturation at both ends and target-only mispredicts are reached within a few updates. A long random phase draws addresses from eight tags over three sets. It mixes response stalls, rare flushes and lookups that coincide with updates to the same branch.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_ON_ALLOC = 2'd2;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_leans_taken(input ctr2_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WAYS-1:0]             row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [TAG_W-1:0]            q_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = row_valid[w] && (row_tag[w] == q_tag);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // R4: allocation only on miss, so a tag never sits in two ways of a set
  a_r4_unique_tag: assert property (@(posedge clk) disable iff (rst) $onehot0(eq));
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              touch_en,
  input  logic [SET_W-1:0]  touch_set,
  input  logic [WAY_W-1:0]  touch_way,
  input  logic [SET_W-1:0]  q_set,
  input  logic [WAYS-1:0]   q_valid,
  output logic [WAY_W-1:0]  victim
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < touched_age)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !q_valid[w]) begin
        found  = 1'b1;
        victim = WAY_W'(w);
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[q_set][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
  end

  // R9: a set with a free way never evicts a live entry
  a_r9_free_way_first: assert property (@(posedge clk) disable iff (rst)
    !(&q_valid) |-> !q_valid[victim]);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              mispredict
);
  localparam int LKP = 0;
  localparam int UPD = 1;

  logic [SETS-1:0][WAYS-1:0]              vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0]  tgt_q;
  logic [SETS-1:0][WAYS-1:0][1:0]         ctr_q;

  logic [1:0][ADDR_W-1:0] p_addr;
  logic [1:0][SET_W-1:0]  p_set;
  logic [1:0][TAG_W-1:0]  p_tag;
  logic [1:0]             p_hit;
  logic [1:0][WAY_W-1:0]  p_way;

  assign p_addr[LKP] = lkp_addr;
  assign p_addr[UPD] = upd_addr;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign p_set[p] = p_addr[p][SET_W-1:0];
    assign p_tag[p] = p_addr[p][ADDR_W-1:SET_W];
    btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .clk(clk), .rst(rst),
      .row_valid(vld_q[p_set[p]]), .row_tag(tag_q[p_set[p]]),
      .q_tag(p_tag[p]), .hit(p_hit[p]), .hit_way(p_way[p])
    );
  end

  // update side: recompute the prediction this branch would get now
  logic              upd_go, alloc, bump, pred_tk, mp_d, touch_en;
  logic [ADDR_W-1:0] pred_tgt;
  logic [WAY_W-1:0]  victim, touch_way;
  ctr2_t             upd_ctr;

  assign upd_go   = upd_valid && !flush;
  assign upd_ctr  = ctr_q[p_set[UPD]][p_way[UPD]];
  assign pred_tk  = p_hit[UPD] && ctr_leans_taken(upd_ctr);
  assign pred_tgt = tgt_q[p_set[UPD]][p_way[UPD]];
  assign mp_d     = upd_go && ((pred_tk != upd_taken) ||
                               (pred_tk && upd_taken && (pred_tgt != upd_target)));
  assign alloc     = upd_go && !p_hit[UPD] && upd_taken;
  assign bump      = upd_go && p_hit[UPD];
  assign touch_en  = alloc || bump;
  assign touch_way = p_hit[UPD] ? p_way[UPD] : victim;

  btb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_set(p_set[UPD]), .touch_way(touch_way),
    .q_set(p_set[UPD]), .q_valid(vld_q[p_set[UPD]]), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      tag_q      <= '0;
      tgt_q      <= '0;
      ctr_q      <= '0;
      mispredict <= 1'b0;
    end else begin
      mispredict <= mp_d;
      if (flush) begin
        vld_q <= '0;
      end else if (alloc) begin
        vld_q[p_set[UPD]][victim] <= 1'b1;
        tag_q[p_set[UPD]][victim] <= p_tag[UPD];
        tgt_q[p_set[UPD]][victim] <= upd_target;
        ctr_q[p_set[UPD]][victim] <= CTR_ON_ALLOC;
      end else if (bump) begin
        ctr_q[p_set[UPD]][p_way[UPD]] <= ctr_step(upd_ctr, upd_taken);
        if (upd_taken) tgt_q[p_set[UPD]][p_way[UPD]] <= upd_target;
      end
    end
  end

  // lookup side: one response register with valid/ready
  logic lkp_fire;
  assign lkp_ready = !rsp_valid || rsp_ready;
  assign lkp_fire  = lkp_valid && lkp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else if (lkp_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= p_hit[LKP];
      rsp_taken  <= p_hit[LKP] && ctr_leans_taken(ctr_q[p_set[LKP]][p_way[LKP]]);
      rsp_target <= p_hit[LKP] ? tgt_q[p_set[LKP]][p_way[LKP]] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r12_stall_holds: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
                                $stable(rsp_taken) && $stable(rsp_target));
  a_r3_miss_is_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> !rsp_taken && (rsp_target == '0));
  a_r8_pulse_follows_update: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(upd_valid && !flush));
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
  a_r5_alloc_flags: assert property (@(posedge clk) disable iff (rst)
    alloc |=> mispredict);
endmodule

// File: tb/btb_predictor_tb.sv
`timescale 1ns/1ps
module btb_predictor_tb;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam int AW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, lkp_valid = 1'b0, rsp_ready = 1'b1;
  logic upd_valid = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] lkp_addr = '0, upd_addr = '0, upd_target = '0;
  logic lkp_ready, rsp_valid, rsp_hit, rsp_taken, mispredict;
  logic [AW-1:0] rsp_target;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  btb_predictor #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_addr(lkp_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_target(upd_target), .mispredict(mispredict)
  );

  // ---------------- behavioural reference ----------------
  bit          m_vld [SETS][WAYS];
  bit [AW-1:0] m_tag [SETS][WAYS];
  bit [AW-1:0] m_tgt [SETS][WAYS];
  int          m_ctr [SETS][WAYS];
  int          m_use [SETS][WAYS];
  int          now = 0;
  bit m_rsp_v = 0, m_hit = 0, m_tk = 0, m_mp = 0;
  bit [AW-1:0] m_tg = 0;

  function automatic int m_find(bit [AW-1:0] a);
    int s = int'(a % SETS);
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == a / SETS) return w;
    return -1;
  endfunction

  always @(posedge clk) begin
    int w, s, v;
    bit ptk;
    now++;
    if (rst) begin
      m_rsp_v = 0; m_mp = 0; m_hit = 0; m_tk = 0; m_tg = 0;
      foreach (m_vld[i, j]) begin m_vld[i][j] = 0; m_use[i][j] = 0; end
    end else begin
      if (lkp_valid && (!m_rsp_v || rsp_ready)) begin
        w = m_find(lkp_addr); s = int'(lkp_addr % SETS);
        m_rsp_v = 1; m_hit = (w >= 0);
        m_tk = m_hit && m_ctr[s][w] >= 2;
        m_tg = m_hit ? m_tgt[s][w] : 0;
      end else if (rsp_ready) m_rsp_v = 0;
      m_mp = 0;
      if (flush) begin
        foreach (m_vld[i, j]) m_vld[i][j] = 0;
      end else if (upd_valid) begin
        w = m_find(upd_addr); s = int'(upd_addr % SETS);
        ptk = (w >= 0) && m_ctr[s][w] >= 2;
        m_mp = (ptk != upd_taken) || (ptk && upd_taken && m_tgt[s][w] != upd_target);
        if (w >= 0) begin
          if (upd_taken) begin
            if (m_ctr[s][w] < 3) m_ctr[s][w]++;
            m_tgt[s][w] = upd_target;
          end else if (m_ctr[s][w] > 0) m_ctr[s][w]--;
          m_use[s][w] = now;
        end else if (upd_taken) begin
          v = -1;
          for (int k = 0; k < WAYS; k++) if (v < 0 && !m_vld[s][k]) v = k;
          if (v < 0) begin
            v = 0;
            for (int k = 1; k < WAYS; k++) if (m_use[s][k] < m_use[s][v]) v = k;
          end
          m_vld[s][v] = 1; m_tag[s][v] = upd_addr / SETS;
          m_tgt[s][v] = upd_target; m_ctr[s][v] = 2; m_use[s][v] = now;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R12 rsp_valid", rsp_valid, m_rsp_v);
      chk("R8 mispredict", mispredict, m_mp);
      if (m_rsp_v) begin
        chk("R4 rsp_hit", rsp_hit, m_hit);
        chk("R4 rsp_taken", rsp_taken, m_tk);
        chk("R4 rsp_target", rsp_target, m_tg);
      end
      #2;
      chk("R12 lkp_ready", lkp_ready, !m_rsp_v || rsp_ready);
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [AW-1:0] mk(int tag, int set);
    return AW'(tag * SETS + set);
  endfunction

  task automatic idle();
    lkp_valid = 0; upd_valid = 0; flush = 0; rsp_ready = 1;
  endtask

  task automatic look(input logic [AW-1:0] a, input bit eh, input bit etk,
                      input logic [AW-1:0] etg, input string req);
    @(negedge clk); idle(); lkp_valid = 1; lkp_addr = a;
    @(negedge clk); idle();
    chk(req, {rsp_valid, rsp_hit, rsp_taken}, {1'b1, eh, etk});
    chk(req, rsp_target, etg);
  endtask

  task automatic upd(input logic [AW-1:0] a, input bit tk, input logic [AW-1:0] tg,
                     input bit emp, input string req);
    @(negedge clk); idle(); upd_valid = 1; upd_addr = a; upd_taken = tk; upd_target = tg;
    @(negedge clk); idle();
    chk(req, mispredict, emp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b;
    a = mk(7, 5); b = mk(9, 1);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mispredict", mispredict, 0);
    chk("R1 lkp_ready", lkp_ready, 1);
    look(a, 0, 0, 0, "R1 R3 miss after reset");
    upd(a, 1, 32'h400, 1, "R5 alloc on taken miss");
    look(a, 1, 1, 32'h400, "R5 hit weakly taken");
    look(a ^ 32'h8000_0000, 0, 0, 0, "R2 tag bits differ");
    upd(b, 0, 32'h0, 0, "R6 not-taken miss quiet");
    look(b, 0, 0, 0, "R6 nothing allocated");
    upd(a, 1, 32'h800, 1, "R8 target mismatch");
    upd(a, 1, 32'h800, 0, "R7 saturate at 3");
    upd(a, 0, 32'h0, 1, "R8 direction 3->2");
    upd(a, 0, 32'h0, 1, "R8 direction 2->1");
    look(a, 1, 0, 32'h800, "R7 counter 1 not taken");
    upd(a, 0, 32'h0, 0, "R7 down to 0");
    upd(a, 0, 32'h0, 0, "R7 saturate at 0");
    // R9 / R10: fill set 2, touch the oldest, then add a fifth
    for (int t = 0; t < WAYS; t++) upd(mk(20 + t, 2), 1, 32'h1000 + t, 1, "R5 fill set");
    upd(mk(20, 2), 1, 32'h1000, 0, "R7 touch way 0");
    upd(mk(30, 2), 1, 32'h2000, 1, "R10 fifth branch");
    look(mk(21, 2), 0, 0, 0, "R9 R10 LRU way displaced");
    look(mk(20, 2), 1, 1, 32'h1000, "R9 touched way kept");
    look(mk(30, 2), 1, 1, 32'h2000, "R10 newcomer present");
    // R11
    @(negedge clk); idle(); flush = 1; upd_valid = 1; upd_addr = mk(3, 9);
    upd_taken = 1; upd_target = 32'h30;
    @(negedge clk); idle();
    chk("R11 no mispredict under flush", mispredict, 0);
    look(a, 0, 0, 0, "R11 flushed entry misses");
    look(mk(3, 9), 0, 0, 0, "R11 update ignored");
    // random phase with stalls, collisions and rare flushes
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      lkp_valid  = ($urandom_range(0, 3) != 0);
      lkp_addr   = mk($urandom_range(0, 7), $urandom_range(0, 2));
      rsp_ready  = ($urandom_range(0, 3) != 0);
      upd_valid  = ($urandom_range(0, 1) != 0);
      upd_addr   = ($urandom_range(0, 3) == 0) ? lkp_addr
                   : mk($urandom_range(0, 7), $urandom_range(0, 2));
      upd_taken  = ($urandom_range(0, 2) != 0);
      upd_target = AW'($urandom_range(0, 3) * 16);
      flush      = ($urandom_range(0, 199) == 0);
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule